// File: doc/BRIEF.md
# Accumulated-Message Final Padding Detector

This block follows a hash message that software submits as a chain of separate requests. Each request is presented on a valid/ready input as its byte length and the last eight bytes of its data. The block keeps a running byte count over the chain. It decides whether the current request is the one carrying the closing padding by reading a bit length from those eight bytes and checking it against the running count. It then fetches a single data byte through a lookup port and checks that byte for the padding start marker.

The verdict leaves on a valid/ready output. It carries a final flag, the offset at which padding begins, the message length to pass to the hash core once padding is trimmed, and a count of the earlier segments that were held back for caching. The output holds its values while the consumer keeps `dec_ready` low. No new request is accepted until the verdict has been taken, so back-pressure on the output stalls the input. The lookup port is a plain request pulse with a response of any latency.

Top module: `pad_detector`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no request is in progress: after reset, and in the cycle after a verdict has been taken.
- R2: On acceptance the running total grows by `req_len`. The check for that request uses the total that already includes it.
- R3: `req_tail` holds the last eight request bytes as a big-endian value, with bits 63:56 being the first of those bytes. The candidate length is `req_tail` shifted right by 3 (bits to bytes). A candidate larger than the running total gives a non-final verdict with no lookup.
- R4: The padding size is total minus candidate, and the padding offset is `req_len` minus that size. When the size is between 1 and `req_len`, `lk_req` pulses for exactly one cycle, in the cycle after acceptance, with `lk_off` set to the offset. Any other size gives a non-final verdict with no lookup.
- R5: The verdict is final only if `lk_byte` equals 0x80 in the cycle where `lk_rsp_valid` is high. `lk_byte` is ignored while `lk_rsp_valid` is low. The verdict is registered on that edge, so `dec_valid` rises one cycle later. When no lookup is made, `dec_valid` rises two cycles after acceptance.
- R6: `dec_trim_len` equals the padding offset on a final verdict and `req_len` otherwise. `dec_pad_off` equals the offset on a final verdict and 0 otherwise.
- R7: A final verdict clears the running total and the segment count. A non-final verdict keeps the total.
- R8: On a non-final verdict the segment count rises by one, saturating at 2^SEG_W-1, and `dec_segs` reports the new count. On a final verdict `dec_segs` reports the count of held-back segments before clearing.
- R9: While `dec_valid` is high and `dec_ready` is low, the verdict outputs stay unchanged and `req_ready` stays low.
- R10: Reset clears the running total and the segment count, drives `req_ready` high, and drives `dec_valid` and `lk_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_len | input | LEN_W | Request byte length |
| req_tail | input | 64 | Last eight request bytes, big-endian |
| lk_req | output | 1 | One-cycle byte lookup request |
| lk_off | output | LEN_W | Byte offset to look up inside the request |
| lk_rsp_valid | input | 1 | Lookup byte returned |
| lk_byte | input | 8 | Returned byte |
| dec_valid | output | 1 | Verdict present |
| dec_ready | input | 1 | Consumer takes the verdict |
| dec_final | output | 1 | Request holds the closing padding |
| dec_pad_off | output | LEN_W | Padding start offset (0 when non-final) |
| dec_trim_len | output | LEN_W | Length to hash from this request |
| dec_segs | output | SEG_W | Held-back segment count |

## Verification
The bench builds the block with LEN_W=6, TOT_W=10 and SEG_W=3. With these widths it can sweep every candidate distance from one byte beyond the running total to one byte beyond the request start, for several request lengths. The sweep covers both the marker byte and a non-marker byte, with varying lookup latency and output stalls. The three-bit segment count lets a short run of non-final requests reach saturation. The small totals let a reset in the middle of a chain, and a candidate taken from an all-ones tail, be checked against arithmetic computed in the bench.

// File: rtl/pad_det_pkg.sv
package pad_det_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } pd_state_e;

  localparam logic [7:0] PAD_MARK = 8'h80;
endpackage

// File: rtl/pad_eval.sv
module pad_eval #(
  parameter int LEN_W = 16,
  parameter int TOT_W = 32
) (
  input  logic [TOT_W-1:0] tot,
  input  logic [LEN_W-1:0] len,
  input  logic [63:0]      cand,
  output logic             in_range,
  output logic [LEN_W-1:0] off
);
  logic             cand_ok;
  logic [TOT_W-1:0] pad_size;

  always_comb begin
    cand_ok  = cand <= 64'(tot);
    pad_size = tot - TOT_W'(cand);
    in_range = cand_ok && (pad_size != '0) && (pad_size <= TOT_W'(len));
    off      = len - LEN_W'(pad_size);
  end
endmodule

// File: rtl/run_tracker.sv
module run_tracker #(
  parameter int LEN_W = 16,
  parameter int TOT_W = 32,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [LEN_W-1:0] acc_len,
  input  logic             decide,
  input  logic             final_i,
  output logic [TOT_W-1:0] tot,
  output logic [SEG_W-1:0] seg,
  output logic [SEG_W-1:0] seg_inc
);
  localparam logic [SEG_W-1:0] SEG_MAX = {SEG_W{1'b1}};

  assign seg_inc = (seg == SEG_MAX) ? seg : seg + SEG_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot <= '0;
      seg <= '0;
    end else begin
      if (acc) tot <= tot + TOT_W'(acc_len);
      else if (decide && final_i) tot <= '0;
      if (decide) seg <= final_i ? '0 : seg_inc;
    end
  end

  p_final_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && final_i) |=> (tot == '0 && seg == '0));

  p_keep_total_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !final_i) |=> $stable(tot));

  p_seg_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !final_i && seg == SEG_MAX) |=> (seg == SEG_MAX));

  p_total_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (tot == $past(tot) + TOT_W'($past(acc_len))));
endmodule

// File: rtl/pad_detector.sv
module pad_detector
  import pad_det_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TOT_W = 32,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  input  logic [63:0]      req_tail,
  output logic             lk_req,
  output logic [LEN_W-1:0] lk_off,
  input  logic             lk_rsp_valid,
  input  logic [7:0]       lk_byte,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic             dec_final,
  output logic [LEN_W-1:0] dec_pad_off,
  output logic [LEN_W-1:0] dec_trim_len,
  output logic [SEG_W-1:0] dec_segs
);
  pd_state_e        st;
  logic [LEN_W-1:0] len_q;
  logic [63:0]      cand_q;
  logic [TOT_W-1:0] tot;
  logic [SEG_W-1:0] seg, seg_inc;
  logic             in_range;
  logic [LEN_W-1:0] off;
  logic             acc, decide, final_now;

  assign req_ready = (st == ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign lk_req    = (st == ST_LOOK) && in_range;
  assign lk_off    = off;
  assign dec_valid = (st == ST_OUT);

  always_comb begin
    decide    = 1'b0;
    final_now = 1'b0;
    if (st == ST_LOOK && !in_range) decide = 1'b1;
    if (st == ST_WAIT && lk_rsp_valid) begin
      decide    = 1'b1;
      final_now = (lk_byte == PAD_MARK);
    end
  end

  pad_eval #(.LEN_W(LEN_W), .TOT_W(TOT_W)) u_eval (
    .tot(tot), .len(len_q), .cand(cand_q), .in_range(in_range), .off(off)
  );

  run_tracker #(.LEN_W(LEN_W), .TOT_W(TOT_W), .SEG_W(SEG_W)) u_track (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_len(req_len),
    .decide(decide), .final_i(final_now),
    .tot(tot), .seg(seg), .seg_inc(seg_inc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      len_q        <= '0;
      cand_q       <= '0;
      dec_final    <= 1'b0;
      dec_pad_off  <= '0;
      dec_trim_len <= '0;
      dec_segs     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          len_q  <= req_len;
          cand_q <= req_tail >> 3;
          st     <= ST_LOOK;
        end
        ST_LOOK: st <= in_range ? ST_WAIT : ST_OUT;
        ST_WAIT: if (lk_rsp_valid) st <= ST_OUT;
        ST_OUT:  if (dec_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (decide) begin
        dec_final    <= final_now;
        dec_pad_off  <= final_now ? off : '0;
        dec_trim_len <= final_now ? off : len_q;
        dec_segs     <= final_now ? seg : seg_inc;
      end
    end
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !req_ready);

  p_lk_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> (lk_off < len_q));

  p_lk_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> !lk_req);

  p_trim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_trim_len <= len_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_final) &&
      $stable(dec_trim_len) && $stable(dec_pad_off) && $stable(dec_segs)));
endmodule

// File: tb/test_pad_detector.sv
module test_pad_detector;
  localparam int LEN_W = 6;
  localparam int TOT_W = 10;
  localparam int SEG_W = 3;
  localparam int SEG_MAX = (1 << SEG_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [LEN_W-1:0] req_len = '0;
  logic [63:0] req_tail = '0;
  logic lk_req;
  logic [LEN_W-1:0] lk_off;
  logic lk_rsp_valid = 1'b0;
  logic [7:0] lk_byte = '0;
  logic dec_valid, dec_ready = 1'b0, dec_final;
  logic [LEN_W-1:0] dec_pad_off, dec_trim_len;
  logic [SEG_W-1:0] dec_segs;

  int n_chk = 0, n_fail = 0;
  longint m_tot = 0;
  int m_seg = 0;

  always #2.5 clk = ~clk;

  pad_detector #(.LEN_W(LEN_W), .TOT_W(TOT_W), .SEG_W(SEG_W)) i_pad_detector (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .req_tail(req_tail), .lk_req(lk_req), .lk_off(lk_off),
    .lk_rsp_valid(lk_rsp_valid), .lk_byte(lk_byte), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_final(dec_final), .dec_pad_off(dec_pad_off),
    .dec_trim_len(dec_trim_len), .dec_segs(dec_segs)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic check_idle(input string tag);
    chk(req_ready == 1'b1, {tag, " req_ready"}, req_ready, 1);
    chk(dec_valid == 1'b0, {tag, " dec_valid"}, dec_valid, 0);
    chk(lk_req == 1'b0, {tag, " lk_req"}, lk_req, 0);
  endtask

  task automatic do_req(input int len, input logic [63:0] tail, input logic [7:0] b,
                        input int lat, input int bp);
    longint unsigned cand, tot_new, psz;
    bit inr, fin;
    int off, exp_segs, sat;
    tot_new = longint'(m_tot) + len;
    cand = tail >> 3;
    inr = 1'b0;
    off = 0;
    if (cand <= tot_new) begin
      psz = tot_new - cand;
      if (psz >= 1 && psz <= longint'(len)) begin
        inr = 1'b1;
        off = len - int'(psz);
      end
    end
    fin = inr && (b == 8'h80);
    sat = (m_seg == SEG_MAX) ? m_seg : m_seg + 1;
    exp_segs = fin ? m_seg : sat;

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_len = LEN_W'(len);
    req_tail = tail;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
    chk(lk_req == inr, "R4 lookup issued iff in range (R3 candidate)", lk_req, inr);
    if (inr) begin
      chk(lk_off == LEN_W'(off), "R4 lookup offset", lk_off, off);
      lk_byte = 8'h80;
      for (int k = 0; k <= lat; k++) begin
        @(negedge clk);
        chk(lk_req == 1'b0, "R4 lookup single pulse", lk_req, 0);
        chk(dec_valid == 1'b0, "R5 no verdict before byte", dec_valid, 0);
      end
      lk_rsp_valid = 1'b1;
      lk_byte = b;
      @(negedge clk);
      lk_rsp_valid = 1'b0;
      lk_byte = 8'h80;
    end else begin
      @(negedge clk);
    end
    chk(dec_valid == 1'b1, "R5 verdict timing", dec_valid, 1);
    chk(dec_final == fin, "R5 final flag", dec_final, fin);
    chk(dec_trim_len == LEN_W'(fin ? off : len), "R6 trimmed length", dec_trim_len, fin ? off : len);
    chk(dec_pad_off == LEN_W'(fin ? off : 0), "R6 pad offset", dec_pad_off, fin ? off : 0);
    chk(dec_segs == SEG_W'(exp_segs), "R8 segment count", dec_segs, exp_segs);
    for (int k = 0; k < bp; k++) begin
      @(negedge clk);
      chk(dec_valid == 1'b1 && dec_final == fin && dec_segs == SEG_W'(exp_segs),
          "R9 verdict held under stall", dec_valid, 1);
      chk(req_ready == 1'b0, "R9 input stalled", req_ready, 0);
    end
    dec_ready = 1'b1;
    @(negedge clk);
    dec_ready = 1'b0;
    chk(dec_valid == 1'b0 && req_ready == 1'b1, "R1 ready after verdict taken", req_ready, 1);
    m_tot = fin ? 0 : tot_new;
    m_seg = fin ? 0 : sat;
  endtask

  function automatic logic [63:0] mk_tail(input longint cand, input int low);
    return 64'(cand) * 64'd8 + 64'(low & 7);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary_and_end();
  end

  initial begin
    int lens[4];
    lens = '{9, 17, 33, 63};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R10 reset state");
    rst_n = 1'b1;

    // R2..R6 sweep of candidate distance, marker byte and latency
    for (int li = 0; li < 4; li++) begin
      for (int d = -1; d <= lens[li] + 1; d++) begin
        for (int b = 0; b < 2; b++) begin
          longint tn, c;
          tn = m_tot + lens[li];
          c = tn - d;
          if (c < 0) c = tn + 1;
          do_req(lens[li], mk_tail(c, d + b), b ? 8'h80 : 8'h7F,
                 (d + li) % 3, (d % 4 == 0) ? 2 : 0);
        end
      end
    end

    // R3: all-ones tail gives a candidate far above the total
    do_req(20, 64'hFFFF_FFFF_FFFF_FFFF, 8'h80, 0, 0);

    // R8: saturation of the segment count, then final reporting it
    for (int k = 0; k < 9; k++) do_req(10, mk_tail(m_tot + 11, k), 8'h80, 1, 0);
    do_req(10, mk_tail(m_tot + 10 - 3, 5), 8'h80, 0, 1);

    // R10: reset in the middle of an accumulated chain
    do_req(12, mk_tail(m_tot + 13, 0), 8'h80, 0, 0);
    do_req(12, mk_tail(m_tot + 13, 0), 8'h80, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R10 mid-chain reset");
    rst_n = 1'b1;
    m_tot = 0;
    m_seg = 0;
    do_req(20, mk_tail(15, 3), 8'h80, 2, 0);

    summary_and_end();
  end
endmodule